// File: doc/BRIEF.md
# Audio Link Frame Serializer

This block is the controller-side sender of a fixed-rate, bit-serial, time-division-multiplexed audio link. It runs on the link's bit clock. It counts 256-bit frames, drives a frame marker (`sync`), and shifts one 16-bit tag slot and then twelve 20-bit data slots out on `sdata`. All outgoing bits change on rising clock edges.

A parallel side gives one valid flag and one 20-bit word per data slot, plus a whole-frame valid flag. The block copies these into a shadow register on the rising edge that starts each frame. It raises `frame_done` for one cycle so that the supplier can present the next frame's contents. The tag slot is assembled from the captured flags. Any slot flagged invalid goes out as zeros, whatever word is presented for it. The serial stream trails the marker by one bit clock.

Top module: `tdm_link_tx`

## Requirements
- R1: `sync` rises once every 256 clock cycles, and the frame length is 16 + 12×20 bits.
- R2: `sync` stays high for exactly 16 consecutive cycles at the start of each frame and is low for the other 240.
- R3: The first tag bit is on `sdata` in the cycle after the cycle in which `sync` rises. In the cycle where `sync` rises, `sdata` still carries the final bit of the previous frame.
- R4: The tag slot is sent MSB first. Tag bit 15 is `frame_valid`. Tag bit 14−i is `slot_valid[i]` (data slot i+1) for i = 0..11. Tag bits 2..0 are 0.
- R5: Data slots follow the tag in order 1 to 12. Each slot is 20 bits, MSB first. Slot k carries `slot_data[(k-1)*20 +: 20]`.
- R6: A data slot whose captured valid flag is 0 is sent as twenty zero bits, whatever its data word holds.
- R7: The inputs are sampled only at the rising edge where `sync` goes high. Changes at any other time do not alter the frame being sent, including the last bit of slot 12, which leaves on that same edge.
- R8: `frame_done` is high for exactly one cycle per frame, and that cycle is the first cycle with `sync` high.
- R9: While `rst_n` is low, `sync`, `sdata` and `frame_done` are 0. The first rising edge after release raises `sync` and `frame_done` and captures the contents of the first frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_valid | input | 1 | Whole-frame valid flag, sent as tag bit 15 |
| slot_valid | input | 12 | Per-slot valid flags; bit i belongs to data slot i+1 |
| slot_data | input | 240 | Slot words; slot k at bits (k-1)*20 +: 20 |
| frame_done | output | 1 | One-cycle strobe: new frame contents captured |
| sync | output | 1 | Frame marker, high during the tag phase |
| sdata | output | 1 | Serial data, MSB first per slot |

## Verification
Two things happen on the same clock edge at every frame boundary: the last bit of slot 12 is sent from the old shadow, and the shadow is loaded with the new frame's flags and words. The bench provokes this collision in a directed case. Mid-frame, it switches the inputs to a pattern whose slot-12 bit 0, slot valid flags and frame flag are all the opposite of the frame being sent. It then judges two things: the sampled final bit must still be the old frame's 1, and the next tag must reflect the new pattern. A second directed case applies reset in the middle of a frame, checks that the outputs go quiet, and confirms that the first frame after release carries the words presented at release.

// File: rtl/tdm_link_pkg.sv
package tdm_link_pkg;
  localparam int DEF_TAG_W  = 16;
  localparam int DEF_SLOTS  = 12;
  localparam int DEF_SLOT_W = 20;

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/tdm_bit_counter.sv
module tdm_bit_counter
  import tdm_link_pkg::*;
#(
  parameter int TAG_W  = DEF_TAG_W,
  parameter int SLOTS  = DEF_SLOTS,
  parameter int SLOT_W = DEF_SLOT_W,
  localparam int FRAME_LEN = TAG_W + SLOTS * SLOT_W,
  localparam int POS_W     = $clog2(FRAME_LEN),
  localparam int SIW       = $clog2(SLOTS + 1),
  localparam int BIT_W     = $clog2(max2(TAG_W, SLOT_W))
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [SIW-1:0]   slot_idx,
  output logic [BIT_W-1:0] bit_idx,
  output logic             frame_last,
  output logic             next_in_tag
);
  localparam logic [POS_W-1:0] LAST_POS  = POS_W'(FRAME_LEN - 1);
  localparam logic [POS_W-1:0] TAG_END   = POS_W'(TAG_W - 1);
  localparam logic [SIW-1:0]   LAST_SLOT = SIW'(SLOTS);
  localparam logic [BIT_W-1:0] TAG_TOP   = BIT_W'(TAG_W - 1);
  localparam logic [BIT_W-1:0] SLOT_TOP  = BIT_W'(SLOT_W - 1);

  logic [POS_W-1:0] pos_q, pos_d;
  logic [SIW-1:0]   slot_q, slot_d;
  logic [BIT_W-1:0] bit_q, bit_d;

  always_comb begin
    pos_d  = (pos_q == LAST_POS) ? '0 : pos_q + 1'b1;
    slot_d = slot_q;
    bit_d  = bit_q;
    if (bit_q == '0) begin
      if (slot_q == LAST_SLOT) begin
        slot_d = '0;
        bit_d  = TAG_TOP;
      end else begin
        slot_d = slot_q + 1'b1;
        bit_d  = SLOT_TOP;
      end
    end else begin
      bit_d = bit_q - 1'b1;
    end
  end

  // Reset parks the counter on the last bit so the first edge opens a frame.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q  <= LAST_POS;
      slot_q <= LAST_SLOT;
      bit_q  <= '0;
    end else begin
      pos_q  <= pos_d;
      slot_q <= slot_d;
      bit_q  <= bit_d;
    end
  end

  assign slot_idx    = slot_q;
  assign bit_idx     = bit_q;
  assign frame_last  = (pos_q == LAST_POS);
  assign next_in_tag = (pos_q == LAST_POS) || (pos_q < TAG_END);

  // R1
  frame_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pos_q == LAST_POS) |-> (slot_q == LAST_SLOT && bit_q == '0));

  // R4
  tag_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_q == '0) |-> (pos_q <= TAG_END && bit_q == BIT_W'(TAG_END - pos_q)));
endmodule

// File: rtl/tdm_slot_shadow.sv
module tdm_slot_shadow
  import tdm_link_pkg::*;
#(
  parameter int SLOTS  = DEF_SLOTS,
  parameter int SLOT_W = DEF_SLOT_W,
  localparam int DATA_W = SLOTS * SLOT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              frame_valid_in,
  input  logic [SLOTS-1:0]  slot_valid_in,
  input  logic [DATA_W-1:0] slot_data_in,
  output logic              frame_valid_q,
  output logic [SLOTS-1:0]  slot_valid_q,
  output logic [DATA_W-1:0] slot_data_q
);
  logic              fv_d;
  logic [SLOTS-1:0]  sv_d;
  logic [DATA_W-1:0] sd_d;

  always_comb begin
    fv_d = frame_valid_q;
    sv_d = slot_valid_q;
    sd_d = slot_data_q;
    if (load) begin
      fv_d = frame_valid_in;
      sv_d = slot_valid_in;
      sd_d = slot_data_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_valid_q <= 1'b0;
      slot_valid_q  <= '0;
      slot_data_q   <= '0;
    end else begin
      frame_valid_q <= fv_d;
      slot_valid_q  <= sv_d;
      slot_data_q   <= sd_d;
    end
  end

  // R7
  shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> ($stable(frame_valid_q) && $stable(slot_valid_q) && $stable(slot_data_q)));
endmodule

// File: rtl/tdm_bit_select.sv
module tdm_bit_select
  import tdm_link_pkg::*;
#(
  parameter int TAG_W  = DEF_TAG_W,
  parameter int SLOTS  = DEF_SLOTS,
  parameter int SLOT_W = DEF_SLOT_W,
  localparam int DATA_W = SLOTS * SLOT_W,
  localparam int SIW    = $clog2(SLOTS + 1),
  localparam int BIT_W  = $clog2(max2(TAG_W, SLOT_W)),
  localparam int SPAN   = 1 << BIT_W
) (
  input  logic              frame_valid_q,
  input  logic [SLOTS-1:0]  slot_valid_q,
  input  logic [DATA_W-1:0] slot_data_q,
  input  logic [SIW-1:0]    slot_idx,
  input  logic [BIT_W-1:0]  bit_idx,
  output logic              bit_o
);
  logic [SPAN-1:0] tag_word;
  logic [SPAN-1:0] data_word;
  logic            data_ok;

  // Tag: frame flag on top, then one flag per slot, remaining bits zero.
  always_comb begin
    tag_word = '0;
    tag_word[TAG_W-1] = frame_valid_q;
    for (int i = 0; i < SLOTS; i++) begin
      tag_word[TAG_W-2-i] = slot_valid_q[i];
    end
  end

  always_comb begin
    data_word = '0;
    data_ok   = 1'b0;
    for (int i = 0; i < SLOTS; i++) begin
      if (slot_idx == SIW'(i + 1)) begin
        data_word[SLOT_W-1:0] = slot_data_q[i*SLOT_W +: SLOT_W];
        data_ok               = slot_valid_q[i];
      end
    end
  end

  assign bit_o = (slot_idx == '0) ? tag_word[bit_idx] : (data_ok & data_word[bit_idx]);
endmodule

// File: rtl/tdm_link_tx.sv
module tdm_link_tx
  import tdm_link_pkg::*;
#(
  parameter int TAG_W  = DEF_TAG_W,
  parameter int SLOTS  = DEF_SLOTS,
  parameter int SLOT_W = DEF_SLOT_W,
  localparam int DATA_W = SLOTS * SLOT_W,
  localparam int SIW    = $clog2(SLOTS + 1),
  localparam int BIT_W  = $clog2(max2(TAG_W, SLOT_W)),
  localparam int RUN_W  = $clog2(TAG_W + 2)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_valid,
  input  logic [SLOTS-1:0]  slot_valid,
  input  logic [DATA_W-1:0] slot_data,
  output logic              frame_done,
  output logic              sync,
  output logic              sdata
);
  logic [SIW-1:0]    slot_idx;
  logic [BIT_W-1:0]  bit_idx;
  logic              frame_last;
  logic              next_in_tag;
  logic              fv_q;
  logic [SLOTS-1:0]  sv_q;
  logic [DATA_W-1:0] sd_q;
  logic              tx_bit;

  logic sync_q, sync_d;
  logic sdata_q, sdata_d;
  logic done_q, done_d;

  tdm_bit_counter #(.TAG_W(TAG_W), .SLOTS(SLOTS), .SLOT_W(SLOT_W)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .slot_idx   (slot_idx),
    .bit_idx    (bit_idx),
    .frame_last (frame_last),
    .next_in_tag(next_in_tag)
  );

  // The shadow loads on the same edge that sends the last bit of the old frame.
  tdm_slot_shadow #(.SLOTS(SLOTS), .SLOT_W(SLOT_W)) u_shadow (
    .clk           (clk),
    .rst_n         (rst_n),
    .load          (frame_last),
    .frame_valid_in(frame_valid),
    .slot_valid_in (slot_valid),
    .slot_data_in  (slot_data),
    .frame_valid_q (fv_q),
    .slot_valid_q  (sv_q),
    .slot_data_q   (sd_q)
  );

  tdm_bit_select #(.TAG_W(TAG_W), .SLOTS(SLOTS), .SLOT_W(SLOT_W)) u_sel (
    .frame_valid_q(fv_q),
    .slot_valid_q (sv_q),
    .slot_data_q  (sd_q),
    .slot_idx     (slot_idx),
    .bit_idx      (bit_idx),
    .bit_o        (tx_bit)
  );

  always_comb begin
    sync_d  = next_in_tag;
    sdata_d = tx_bit;
    done_d  = frame_last;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q  <= 1'b0;
      sdata_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      sync_q  <= sync_d;
      sdata_q <= sdata_d;
      done_q  <= done_d;
    end
  end

  assign sync       = sync_q;
  assign sdata      = sdata_q;
  assign frame_done = done_q;

  // Checker state: length of the current run of sync high.
  logic [RUN_W-1:0] sync_run;
  logic             cur_slot_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_run <= '0;
    else if (sync_q) sync_run <= (sync_run == RUN_W'(TAG_W + 1)) ? sync_run : sync_run + 1'b1;
    else sync_run <= '0;
  end

  always_comb begin
    cur_slot_ok = 1'b0;
    for (int i = 0; i < SLOTS; i++) begin
      if (slot_idx == SIW'(i + 1)) cur_slot_ok = sv_q[i];
    end
  end

  // R2
  sync_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sync_q) |-> (sync_run == RUN_W'(TAG_W)));

  // R2
  sync_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sync_run <= RUN_W'(TAG_W));

  // R8
  done_at_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> $rose(sync_q));

  // R8
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  // R3
  tag_lag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sync_q) |-> (slot_idx == '0 && bit_idx == BIT_W'(TAG_W - 1)));

  // R6
  zero_stuff_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_idx != '0 && !cur_slot_ok) |=> !sdata_q);

  // R9
  always @(posedge clk) begin
    if (!rst_n) begin
      reset_quiet_chk: assert (!sync_q && !sdata_q && !done_q);
    end
  end
endmodule

// File: tb/tb_tdm_link_tx.sv
module tb_tdm_link_tx;
  localparam int SLOTS  = 12;
  localparam int SLOT_W = 20;
  localparam int TAG_W  = 16;
  localparam int FLEN   = TAG_W + SLOTS * SLOT_W;

  logic                    clk = 1'b0;
  logic                    rst_n;
  logic                    frame_valid;
  logic [SLOTS-1:0]        slot_valid;
  logic [SLOTS*SLOT_W-1:0] slot_data;
  logic                    frame_done, sync, sdata;

  int checks = 0;
  int fails  = 0;

  logic                    exp_fv;
  logic [SLOTS-1:0]        exp_sv;
  logic [SLOTS*SLOT_W-1:0] exp_sd;
  logic [FLEN-1:0]         got_bit, got_sync, got_done;

  always #2 clk = ~clk;

  tdm_link_tx dut (
    .clk(clk), .rst_n(rst_n), .frame_valid(frame_valid), .slot_valid(slot_valid),
    .slot_data(slot_data), .frame_done(frame_done), .sync(sync), .sdata(sdata)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  function automatic logic [SLOT_W-1:0] pat(input int seed, input int k);
    logic [31:0] v;
    v = (seed * 32'h0009_E377) ^ (k * 32'h0001_F3A5) ^ 32'h0005_A5A5;
    return v[SLOT_W-1:0];
  endfunction

  task automatic drive(input logic fv, input logic [SLOTS-1:0] sv, input int seed);
    frame_valid = fv;
    slot_valid  = sv;
    for (int k = 0; k < SLOTS; k++) slot_data[k*SLOT_W +: SLOT_W] = pat(seed, k);
    exp_fv = fv;
    exp_sv = sv;
    exp_sd = slot_data;
  endtask

  // Starts in the cycle where frame_done is high (or waits for it), collects 256 bits.
  task automatic collect(input bit perturb);
    logic [TAG_W-1:0]  gt, et;
    logic [SLOT_W-1:0] gw, ew;
    int sync_bad;
    int done_bad;
    while (frame_done !== 1'b1) @(negedge clk);
    check(sync === 1'b1, "R8", "sync in frame_done cycle", {31'b0, sync}, 32'd1);
    for (int i = 0; i < FLEN; i++) begin
      @(negedge clk);
      got_bit[i]  = sdata;
      got_sync[i] = sync;
      got_done[i] = frame_done;
      if (perturb && i == 200) begin
        frame_valid = ~exp_fv;
        slot_valid  = ~exp_sv;
        slot_data   = ~exp_sd;
      end
    end
    sync_bad = 0;
    done_bad = 0;
    for (int i = 0; i < FLEN; i++) begin
      if (got_sync[i] !== ((i < TAG_W - 1) || (i == FLEN - 1))) sync_bad++;
      if (got_done[i] !== (i == FLEN - 1)) done_bad++;
    end
    check(sync_bad == 0, "R2", "sync pattern mismatches", sync_bad, 0);
    check(done_bad == 0, "R1", "frame_done period mismatches", done_bad, 0);
    et = '0;
    et[TAG_W-1] = exp_fv;
    for (int k = 0; k < SLOTS; k++) et[TAG_W-2-k] = exp_sv[k];
    for (int j = 0; j < TAG_W; j++) gt[TAG_W-1-j] = got_bit[j];
    check(gt === et, "R4", "tag slot", {16'b0, gt}, {16'b0, et});
    for (int k = 0; k < SLOTS; k++) begin
      for (int j = 0; j < SLOT_W; j++) gw[SLOT_W-1-j] = got_bit[TAG_W + k*SLOT_W + j];
      ew = exp_sv[k] ? exp_sd[k*SLOT_W +: SLOT_W] : '0;
      if (exp_sv[k]) check(gw === ew, "R5", $sformatf("slot %0d word", k + 1), {12'b0, gw}, {12'b0, ew});
      else check(gw === ew, "R6", $sformatf("slot %0d stuffing", k + 1), {12'b0, gw}, {12'b0, ew});
    end
    @(negedge clk);
  endtask

  task automatic t_reset_start();
    rst_n = 1'b0;
    drive(1'b0, '0, 0);
    repeat (3) @(negedge clk);
    check({sync, sdata, frame_done} === 3'b000, "R9", "outputs in reset",
          {29'b0, sync, sdata, frame_done}, 32'd0);
    drive(1'b1, 12'hFFF, 1);
    rst_n = 1'b1;
    @(negedge clk);
    check(sync === 1'b1 && frame_done === 1'b1, "R9", "first edge opens frame",
          {30'b0, sync, frame_done}, 32'd3);
    check(sdata === 1'b0, "R3", "sdata in sync-rise cycle", {31'b0, sdata}, 32'd0);
    collect(1'b0);
    check(got_bit[0] === 1'b1, "R3", "tag MSB one cycle after sync", {31'b0, got_bit[0]}, 32'd1);
  endtask

  task automatic t_pcm_and_control();
    drive(1'b1, 12'b0000_0000_1111, 2);
    collect(1'b0);
  endtask

  task automatic t_all_idle();
    drive(1'b0, 12'h000, 3);
    slot_data = '1;
    exp_sd    = '1;
    collect(1'b0);
  endtask

  task automatic t_sparse();
    drive(1'b1, 12'b1010_0101_1001, 4);
    collect(1'b0);
  endtask

  task automatic t_boundary_collision();
    drive(1'b1, 12'hFFF, 5);
    slot_data[(SLOTS-1)*SLOT_W] = 1'b1;
    exp_sd = slot_data;
    collect(1'b1);
    check(got_bit[FLEN-1] === 1'b1, "R7", "slot 12 last bit at boundary",
          {31'b0, got_bit[FLEN-1]}, 32'd1);
    exp_fv = ~exp_fv;
    exp_sv = ~exp_sv;
    exp_sd = ~exp_sd;
    collect(1'b0);
  endtask

  task automatic t_mid_reset();
    drive(1'b1, 12'h0F0, 6);
    repeat (50) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check({sync, sdata, frame_done} === 3'b000, "R9", "outputs after mid-frame reset",
          {29'b0, sync, sdata, frame_done}, 32'd0);
    drive(1'b1, 12'h3C3, 7);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(sync === 1'b1 && frame_done === 1'b1, "R9", "frame restart after reset",
          {30'b0, sync, frame_done}, 32'd3);
    collect(1'b0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL R1 watchdog: actual cycles=100000 expected run to finish sooner");
    summary();
    $finish;
  end

  initial begin
    frame_valid = 1'b0;
    slot_valid  = '0;
    slot_data   = '0;
    rst_n       = 1'b0;
    t_reset_start();
    t_pcm_and_control();
    t_all_idle();
    t_sparse();
    t_boundary_collision();
    t_mid_reset();
    summary();
    $finish;
  end
endmodule